// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial line. It uses a clock-enable pulse that runs at sixteen times the bit rate. A falling edge on the idle-high line opens a frame, and the receiver checks that edge again in the middle of the start bit. It then samples five to eight data bits, least significant first, an optional parity bit and one stop bit, each in the middle of its sixteen-tick bit period. Word length and parity mode come from static configuration inputs.

The character goes into a holding register. The data-ready flag and the four per-character error flags are written together on one fixed sub-tick of the stop bit: the 11th. The error flags are overrun, framing, parity and line break. Overrun is decided by an earlier deadline, the 8th tick of that same stop bit. If the host has not emptied the holding register by then, the new character is flagged as overrunning it. A one-cycle read strobe empties the holding register.

Top module: `uart_rx_os`

## Requirements
- R1: Each bit lasts 16 ticks of `tick16_i`. The line is sampled on the 8th tick of each start, data, parity and stop bit. The tick on which a low level is first seen while idle counts as tick 1 of the start bit.
- R2: If the line is high at the 8th tick of the start bit, the frame is dropped as a false start and the receiver returns to idle. Nothing is stored and no flag changes.
- R3: The first data bit on the line lands in `data_o[0]`. `word_len_i` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Unused upper bits of `data_o` read as 0.
- R4: `par_mode_i` code 1 selects even parity and code 2 selects odd parity; codes 0 and 3 mean no parity bit. `par_err_o` is set when the data bits and the parity bit together have the wrong parity.
- R5: `frame_err_o` is set when the stop-bit sample is low.
- R6: `break_o` is set when all data bits are 0, the parity bit (if enabled) is 0 and the stop bit is 0. A break always also sets `frame_err_o`.
- R7: `data_o`, `ready_o` and all four error flags change only on the 11th tick of the stop bit. At the end of the 10th tick they still hold their previous values.
- R8: A one-cycle pulse on `rd_i` clears `ready_o` in the next cycle and leaves `data_o` unchanged. When `rd_i` and a character completion fall in the same cycle, the completion wins.
- R9: `overrun_o` is set for a new character if `ready_o` was still set after the 8th tick of its stop bit. A read between the 8th and 11th ticks is too late. A character whose predecessor was read in time clears `overrun_o`.
- R10: Every completed character replaces all four error flags. Error flags are not sticky, and they are written whether or not the previous character was read.
- R11: After reset, `ready_o`, `data_o` and all error flags are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Clock enable at 16x the bit rate |
| rxd_i | input | 1 | Serial input line, idle high |
| word_len_i | input | 2 | Data bits per character minus five |
| par_mode_i | input | 2 | 0/3 none, 1 even, 2 odd |
| rd_i | input | 1 | Host read strobe, empties holding register |
| data_o | output | 8 | Received character |
| ready_o | output | 1 | Holding register full |
| overrun_o | output | 1 | Previous character not read by deadline |
| frame_err_o | output | 1 | Stop bit sampled low |
| par_err_o | output | 1 | Parity mismatch |
| break_o | output | 1 | Line held low for a whole character |

## Verification
The bench places host reads on both sides of the overrun deadline. A read just before the 8th stop-bit tick must not produce an overrun, and a read just after it must. A design that sampled the deadline at commit time would miss the late-read overrun. The bench also checks that the outputs are unchanged after the 10th stop tick and changed after the 11th, which catches commits placed one tick early or late. Further cases are a short low glitch that must be rejected as a false start, breaks with and without a parity bit, and short words with odd and even parity. A design that left the high data bits unmasked, or kept error flags sticky across characters, would show wrong data or stale flags on the next clean character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int unsigned MAX_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_OFF = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                frame_err;
    logic                par_err;
    logic                brk;
  } rx_char_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{INIT}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rx_tick_timer.sv
module rx_tick_timer #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SAMPLE_AT   = 8,
  parameter int unsigned COMMIT_AT   = 11,
  parameter int unsigned DEADLINE_AT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  input  logic run_i,
  output logic mid_o,
  output logic commit_o,
  output logic deadline_o,
  output logic end_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST   = CW'(OVS - 1);
  localparam logic [CW-1:0] MID_M1 = CW'(SAMPLE_AT - 1);
  localparam logic [CW-1:0] COM_M1 = CW'(COMMIT_AT - 1);
  localparam logic [CW-1:0] DL_M1  = CW'(DEADLINE_AT - 1);

  logic [CW-1:0] cnt_q;

  // load marks the detecting tick as tick 1 of the start bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= CW'(1);
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  wire step = run_i & tick_i;
  assign mid_o      = step & (cnt_q == MID_M1);
  assign commit_o   = step & (cnt_q == COM_M1);
  assign deadline_o = step & (cnt_q == DL_M1);
  assign end_o      = step & (cnt_q == LAST);

  assert_run_from_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> $past(load_i));
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned MIN_BITS = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] word_len_i,
  input  logic [1:0] par_mode_i,
  input  logic       mid_i,
  input  logic       commit_i,
  input  logic       deadline_i,
  input  logic       end_i,
  output logic       load_o,
  output logic       run_o,
  output logic       done_o,
  output logic       deadline_o,
  output rx_char_t   char_o
);
  localparam int unsigned IW = $clog2(MAX_BITS);

  rx_state_e           state_q;
  logic [IW-1:0]       idx_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic                par_q, stop_q;

  logic          par_en, par_odd;
  logic [IW-1:0] last_idx;

  assign par_en   = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
  assign par_odd  = (par_mode_i == PAR_ODD);
  assign last_idx = IW'(MIN_BITS - 1) + IW'(word_len_i);

  assign load_o     = (state_q == RX_IDLE) & tick_i & ~rxd_i;
  assign run_o      = (state_q != RX_IDLE);
  assign done_o     = (state_q == RX_STOP) & commit_i;
  assign deadline_o = (state_q == RX_STOP) & deadline_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      unique case (state_q)
        RX_IDLE: if (load_o) begin
          state_q <= RX_START;
          shreg_q <= '0;
          par_q   <= 1'b0;
        end
        RX_START: begin
          if (mid_i && rxd_i) state_q <= RX_IDLE;   // false start
          else if (end_i) begin
            state_q <= RX_DATA;
            idx_q   <= '0;
          end
        end
        RX_DATA: begin
          if (mid_i) shreg_q[idx_q] <= rxd_i;
          if (end_i) begin
            if (idx_q == last_idx) state_q <= par_en ? RX_PAR : RX_STOP;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (mid_i) par_q <= rxd_i;
          if (end_i) state_q <= RX_STOP;
        end
        RX_STOP: begin
          if (mid_i) stop_q <= rxd_i;
          if (commit_i) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign char_o.data      = shreg_q;
  assign char_o.frame_err = ~stop_q;
  assign char_o.par_err   = par_en & (^shreg_q ^ par_q ^ par_odd);
  assign char_o.brk       = ~|shreg_q & ~par_q & ~stop_q;

  assert_false_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && mid_i && rxd_i) |=> (state_q == RX_IDLE));
  assert_done_in_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import uart_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic                deadline_i,
  input  logic                rd_i,
  input  rx_char_t            char_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                ready_o,
  output logic                overrun_o,
  output logic                frame_err_o,
  output logic                par_err_o,
  output logic                break_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      ready_o     <= 1'b0;
      overrun_o   <= 1'b0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
      break_o     <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      // unread at deadline means the new character overruns it
      if (deadline_i) pend_q <= ready_o & ~rd_i;
      if (done_i) begin
        data_o      <= char_i.data;
        ready_o     <= 1'b1;
        overrun_o   <= pend_q;
        frame_err_o <= char_i.frame_err;
        par_err_o   <= char_i.par_err;
        break_o     <= char_i.brk;
      end else if (rd_i) begin
        ready_o <= 1'b0;
      end
    end
  end

  assert_ready_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !ready_o);
  assert_data_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o));
  assert_overrun_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(done_i));
  assert_break_frames_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> frame_err_o);
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SAMPLE_AT   = 8,
  parameter int unsigned COMMIT_AT   = 11,
  parameter int unsigned DEADLINE_AT = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick16_i,
  input  logic                rxd_i,
  input  logic [1:0]          word_len_i,
  input  logic [1:0]          par_mode_i,
  input  logic                rd_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                ready_o,
  output logic                overrun_o,
  output logic                frame_err_o,
  output logic                par_err_o,
  output logic                break_o
);
  logic rxd_s, load, run, mid, commit, deadline, bit_end, done, stop_deadline;
  rx_char_t chr;

  rx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rxd_s)
  );

  rx_tick_timer #(
    .OVS(OVS), .SAMPLE_AT(SAMPLE_AT), .COMMIT_AT(COMMIT_AT), .DEADLINE_AT(DEADLINE_AT)
  ) u_timer (
    .clk_i, .rst_ni, .tick_i(tick16_i), .load_i(load), .run_i(run),
    .mid_o(mid), .commit_o(commit), .deadline_o(deadline), .end_o(bit_end)
  );

  rx_frame_ctrl u_ctrl (
    .clk_i, .rst_ni, .tick_i(tick16_i), .rxd_i(rxd_s),
    .word_len_i, .par_mode_i,
    .mid_i(mid), .commit_i(commit), .deadline_i(deadline), .end_i(bit_end),
    .load_o(load), .run_o(run), .done_o(done), .deadline_o(stop_deadline),
    .char_o(chr)
  );

  rx_holding u_hold (
    .clk_i, .rst_ni, .done_i(done), .deadline_i(stop_deadline), .rd_i,
    .char_i(chr), .data_o, .ready_o, .overrun_o, .frame_err_o, .par_err_o, .break_o
  );
endmodule

// File: tb/tb_uart_rx_os.sv
`timescale 1ns/1ps
module tb_uart_rx_os;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, rd = 1'b0;
  logic [1:0] wl = 2'd3, pm = 2'd0;
  logic [7:0] data;
  logic       ready, ov, fe, pe, brk;

  int n_chk = 0, n_fail = 0;
  bit mdl_ready = 1'b0;

  typedef struct { logic [7:0] d; bit ov, fe, pe, brk; } exp_t;
  exp_t q[$];
  event commit_ev;

  always #2 clk = ~clk;  // 250 MHz

  uart_rx_os dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .word_len_i(wl), .par_mode_i(pm), .rd_i(rd),
    .data_o(data), .ready_o(ready), .overrun_o(ov),
    .frame_err_o(fe), .par_err_o(pe), .break_o(brk)
  );

  // 16x tick: one cycle in four
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      tick = (k % 4 == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk iff tick == 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic host_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    mdl_ready = 1'b0;
  endtask

  // rd_mode: 0 no read, 1 read before stop tick 8, 2 read after stop tick 8
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v,
                            input int rd_mode);
    int   nb = 5 + int'(wl);
    logic [7:0] m = 8'hFF >> (8 - nb);
    bit   pen = (pm == 2'd1) || (pm == 2'd2);
    logic p = (^(d & m)) ^ (pm == 2'd2) ^ bad_par;
    exp_t e;
    bit   ov_exp;
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (pen) begin
      rxd = p;
      wait_ticks(16);
    end
    rxd = stop_v;
    wait_ticks(7);
    if (rd_mode == 1) host_read();
    ov_exp = mdl_ready;
    wait_ticks(1);
    if (rd_mode == 2) host_read();
    wait_ticks(2);
    // after stop tick 10: still the old state (R7)
    chk("R7 ready before tick 11", ready, mdl_ready);
    e.d   = d & m;
    e.ov  = ov_exp;
    e.fe  = !stop_v;
    e.pe  = pen && bad_par;
    e.brk = ((d & m) == 8'h00) && (!pen || p == 1'b0) && !stop_v;
    q.push_back(e);
    wait_ticks(1);
    mdl_ready = 1'b1;
    -> commit_ev;
    if (!stop_v) rxd = 1'b1;
    wait_ticks(5);
    rxd = 1'b1;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    bit prev_err = 1'b0;
    forever begin
      @(commit_ev);
      if (q.size() == 0) begin
        chk("R7 unexpected completion", 1, 0);
      end else begin
        e = q.pop_front();
        chk("R3 data", data, e.d);  // sampling point R1
        chk("R7 ready", ready, 1);
        chk("R9 overrun", ov, e.ov);
        chk("R5 framing", fe, e.fe);
        chk("R4 parity", pe, e.pe);
        chk("R6 break", brk, e.brk);
        if (prev_err) chk("R10 flags replaced", {ov, fe, pe, brk}, {e.ov, e.fe, e.pe, e.brk});
        prev_err = e.fe | e.pe | e.brk | e.ov;
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {data, ready, ov, fe, pe, brk}, 13'h0);
    rst_n = 1'b1;
    wait_ticks(20);

    // 8 bits, no parity; overrun cases R9
    wl = 2'd3; pm = 2'd0;
    send_frame(8'hA5, 0, 1, 0);
    send_frame(8'h5A, 0, 1, 1);   // read in time
    send_frame(8'h81, 0, 1, 2);   // read too late
    send_frame(8'h0F, 0, 1, 0);   // no read
    host_read();
    wait_ticks(1);
    // R8 read clears ready, keeps data
    chk("R8 ready cleared", ready, 0);
    chk("R8 data kept", data, 8'h0F);
    send_frame(8'hC3, 0, 1, 0);   // clean, overrun cleared

    // short words with parity R3 R4
    wl = 2'd0; pm = 2'd1;
    send_frame(8'hF5, 0, 1, 1);
    send_frame(8'h0A, 1, 1, 1);
    wl = 2'd2; pm = 2'd2;
    send_frame(8'h55, 0, 1, 1);
    wl = 2'd1; pm = 2'd2;
    send_frame(8'h2D, 1, 1, 1);
    wl = 2'd2; pm = 2'd3;         // code 3 = no parity
    send_frame(8'h7E, 0, 1, 1);

    // framing and break R5 R6
    wl = 2'd3; pm = 2'd0;
    send_frame(8'h96, 0, 0, 1);
    send_frame(8'h00, 0, 0, 1);
    pm = 2'd1;
    send_frame(8'h00, 0, 0, 1);
    pm = 2'd2;
    send_frame(8'h00, 0, 0, 1);   // parity bit high: no break
    pm = 2'd0;
    send_frame(8'h3C, 0, 1, 1);

    // false start R2
    host_read();
    keep = data;
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(40);
    chk("R2 false start ready", ready, 0);
    chk("R2 false start data", data, keep);
    chk("R2 false start flags", {ov, fe, pe, brk}, 4'h0);
    send_frame(8'h69, 0, 1, 0);

    wait_ticks(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule